// File: doc/BRIEF.md
# Indexed Semaphore Command Unit

This block holds a bank of counting semaphores and executes 32-bit semaphore command words handed to it by a request processor. Each word carries an enable flag, two fence flags tied to the direction of outstanding DMA traffic, a three-bit operation, a phase flag, a semaphore index and a 12-bit operand. Set, increment and decrement finish in the cycle they are presented. The wait operations hold the requester off through a blocked output until their condition holds. One wait operation tests for a count above zero and takes one unit in the same cycle.

The requester holds `cmd_valid` and `cmd_word` steady until `cmd_done` is high. `cmd_phase` tells the unit which stage of its request the processor is in. A command whose phase flag names the other stage is skipped and has no effect. A second port lets the workload side raise or lower any semaphore at any time, and this is how waits are released. The fence conditions come from two level inputs that say whether all to-device or all from-device transfers have drained.

Top module: `sem_cmd_unit`

## Requirements
- R1: After reset every semaphore reads 0 and the sticky error flag is low.
- R2: A command word with bit 31 clear completes at once (`cmd_done` high, `cmd_blocked` low) and changes no semaphore.
- R3: An enabled command runs only when bit 22 equals `cmd_phase` (0 means after the transfer, 1 means gating it). Otherwise it completes at once with no effect.
- R4: Opcode 1 in bits 26:24 completes at once and loads the semaphore selected by bits 20:16 with bits 11:0 at the next clock edge.
- R5: Opcode 2 adds one and opcode 3 subtracts one, both completing at once. Increment saturates at 4095 and decrement saturates at 0.
- R6: Opcode 4 waits until the semaphore equals bits 11:0, and opcode 5 waits until it is greater than or equal to them. While waiting, `cmd_blocked` is high and `cmd_done` low. When the wait completes, the value is unchanged.
- R7: Opcode 6 is blocked while the semaphore is 0. Once the semaphore is non-zero, it completes and decrements it by one in the same cycle as the test.
- R8: Bit 30 blocks an active command while `to_dev_idle` is low, and bit 29 blocks it while `from_dev_idle` is low.
- R9: Opcode 0 completes with no effect. Opcode 7 completes, changes no semaphore and sets `err_sticky`, which stays high until reset.
- R10: The external port (`ext_dec` 0 = add one, 1 = subtract one) updates semaphore `ext_idx` at the clock edge, with the same saturation as R5.
- R11: When the command and the external port hit the same semaphore in one cycle, both changes take effect. A set loads its value first and then the external change is applied. For adds and subtracts the net change is applied and the result is clamped to 0..4095.
- R12: The reserved bits 28:27, 23, 21 and 15:12 do not affect any result.
- R13: `cmd_done` and `cmd_blocked` are both low when `cmd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command word present |
| cmd_word | input | 32 | Semaphore command word |
| cmd_phase | input | 1 | Current request stage: 0 after the transfer, 1 before it |
| to_dev_idle | input | 1 | All to-device transfers have finished |
| from_dev_idle | input | 1 | All from-device transfers have finished |
| ext_valid | input | 1 | Workload-side update request |
| ext_dec | input | 1 | 0 adds one, 1 subtracts one |
| ext_idx | input | 5 | Semaphore hit by the workload-side update |
| rd_idx | input | 5 | Semaphore to observe |
| rd_value | output | 12 | Current value of semaphore `rd_idx` |
| cmd_done | output | 1 | Command completes this cycle |
| cmd_blocked | output | 1 | Command is waiting on a fence or condition |
| err_sticky | output | 1 | A reserved opcode was executed |

## Verification
The hardest case to reach is a collision in which the command and the external port hit the same semaphore in one cycle, especially an atomic take when the count is one and the external side subtracts at the same edge. The stimulus first sets up the count with a set command. It then presents the colliding command and external update in the same driven cycle. The waits are released by stepping the external port one cycle at a time while the command stays blocked, so that the cycle in which the condition first holds is checked exactly. A long random phase then aims both ports at a few semaphores to make collisions frequent. The behavioural model is compared with the design on every clock.

// File: rtl/sem_pkg.sv
package sem_pkg;
   localparam int WORD_W = 32;
   localparam int IMM_W  = 12;
   localparam int FLD_W  = 5;

   typedef enum logic [2:0] {
      OP_NOP  = 3'd0,
      OP_SET  = 3'd1,
      OP_INC  = 3'd2,
      OP_DEC  = 3'd3,
      OP_WEQ  = 3'd4,
      OP_WGE  = 3'd5,
      OP_TAKE = 3'd6,
      OP_RSVD = 3'd7
   } sem_op_e;

   typedef struct packed {
      logic             en;
      logic             fence_to;
      logic             fence_from;
      sem_op_e          op;
      logic             pre;
      logic [FLD_W-1:0] idx;
      logic [IMM_W-1:0] imm;
   } sem_cmd_t;
endpackage

// File: rtl/sem_decode.sv
module sem_decode
   import sem_pkg::*;
(
   input  logic [WORD_W-1:0] word,
   output sem_cmd_t          cmd
);
   always_comb begin
      cmd.en         = word[31];
      cmd.fence_to   = word[30];
      cmd.fence_from = word[29];
      cmd.op         = sem_op_e'(word[26:24]);
      cmd.pre        = word[22];
      cmd.idx        = word[20:16];
      cmd.imm        = word[11:0];
   end
endmodule

// File: rtl/sem_cond.sv
module sem_cond
   import sem_pkg::*;
#(
   parameter int SEM_W = 12
) (
   input  logic              valid,
   input  sem_cmd_t          cmd,
   input  logic              phase,
   input  logic              to_idle,
   input  logic              from_idle,
   input  logic [SEM_W-1:0]  cur,
   output logic              blocked,
   output logic              done,
   output logic              apply,
   output logic              set_en,
   output logic signed [1:0] delta,
   output logic              rsvd_hit
);
   logic             active;
   logic             ready;
   logic [SEM_W-1:0] imm_x;

   assign imm_x  = SEM_W'(cmd.imm);
   assign active = cmd.en && (cmd.pre == phase);

   always_comb begin
      ready = (!cmd.fence_to || to_idle) && (!cmd.fence_from || from_idle);
      unique case (cmd.op)
         OP_WEQ:  ready = ready && (cur == imm_x);
         OP_WGE:  ready = ready && (cur >= imm_x);
         OP_TAKE: ready = ready && (cur != '0);
         default: ;
      endcase
   end

   assign blocked = valid && active && !ready;
   assign done    = valid && !blocked;
   assign apply   = done && active;

   always_comb begin
      set_en   = 1'b0;
      delta    = 2'sd0;
      rsvd_hit = 1'b0;
      if (apply) begin
         unique case (cmd.op)
            OP_SET:          set_en   = 1'b1;
            OP_INC:          delta    = 2'sd1;
            OP_DEC, OP_TAKE: delta    = -2'sd1;
            OP_RSVD:         rsvd_hit = 1'b1;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
   parameter int NUM_SEM = 32,
   parameter int SEM_W   = 12,
   parameter int IDX_W   = 5
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [IDX_W-1:0]                upd_idx,
   input  logic                            upd_set,
   input  logic [SEM_W-1:0]                upd_val,
   input  logic signed [1:0]               upd_delta,
   input  logic                            ext_valid,
   input  logic [IDX_W-1:0]                ext_idx,
   input  logic signed [1:0]               ext_delta,
   output logic [NUM_SEM-1:0][SEM_W-1:0]   sem_q
);
   localparam int SW = SEM_W + 3;
   localparam logic signed [SW-1:0] MAXV = {3'b000, {SEM_W{1'b1}}};

   for (genvar g = 0; g < NUM_SEM; g++) begin : g_sem
      logic                   cmd_hit;
      logic                   ext_hit;
      logic [SEM_W-1:0]       base;
      logic signed [1:0]      d_cmd;
      logic signed [1:0]      d_ext;
      logic signed [SW-1:0]   sum;
      logic [SEM_W-1:0]       nxt;

      always_comb begin
         cmd_hit = (upd_idx == IDX_W'(g));
         ext_hit = ext_valid && (ext_idx == IDX_W'(g));
         base    = (cmd_hit && upd_set) ? upd_val : sem_q[g];
         d_cmd   = cmd_hit ? upd_delta : 2'sd0;
         d_ext   = ext_hit ? ext_delta : 2'sd0;
         sum     = $signed({3'b000, base})
                 + $signed({{(SW-2){d_cmd[1]}}, d_cmd})
                 + $signed({{(SW-2){d_ext[1]}}, d_ext});
         if (sum < 0)
            nxt = '0;
         else if (sum > MAXV)
            nxt = MAXV[SEM_W-1:0];
         else
            nxt = sum[SEM_W-1:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sem_q[g] <= '0;
         else        sem_q[g] <= nxt;
      end
   end
endmodule

// File: rtl/sem_cmd_unit.sv
module sem_cmd_unit
   import sem_pkg::*;
#(
   parameter int NUM_SEM = 32,
   parameter int SEM_W   = 12,
   parameter int IDX_W   = $clog2(NUM_SEM)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [31:0]        cmd_word,
   input  logic               cmd_phase,
   input  logic               to_dev_idle,
   input  logic               from_dev_idle,
   input  logic               ext_valid,
   input  logic               ext_dec,
   input  logic [IDX_W-1:0]   ext_idx,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [SEM_W-1:0]   rd_value,
   output logic               cmd_done,
   output logic               cmd_blocked,
   output logic               err_sticky
);
   if (NUM_SEM != 32 || IDX_W != FLD_W) begin : g_bad_count
      $error("sem_cmd_unit: index field addresses exactly 32 semaphores");
   end
   if (SEM_W < IMM_W) begin : g_bad_width
      $error("sem_cmd_unit: semaphore narrower than the operand");
   end

   sem_cmd_t                   cmd;
   logic [NUM_SEM-1:0][SEM_W-1:0] sem_q;
   logic                       apply;
   logic                       set_en;
   logic signed [1:0]          delta;
   logic                       rsvd_hit;
   logic signed [1:0]          ext_delta;

   sem_decode u_dec (.word(cmd_word), .cmd(cmd));

   sem_cond #(.SEM_W(SEM_W)) u_cond (
      .valid     (cmd_valid),
      .cmd       (cmd),
      .phase     (cmd_phase),
      .to_idle   (to_dev_idle),
      .from_idle (from_dev_idle),
      .cur       (sem_q[cmd.idx]),
      .blocked   (cmd_blocked),
      .done      (cmd_done),
      .apply     (apply),
      .set_en    (set_en),
      .delta     (delta),
      .rsvd_hit  (rsvd_hit)
   );

   assign ext_delta = ext_dec ? -2'sd1 : 2'sd1;

   sem_bank #(.NUM_SEM(NUM_SEM), .SEM_W(SEM_W), .IDX_W(IDX_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd_idx   (cmd.idx),
      .upd_set   (set_en),
      .upd_val   (SEM_W'(cmd.imm)),
      .upd_delta (delta),
      .ext_valid (ext_valid),
      .ext_idx   (ext_idx),
      .ext_delta (ext_delta),
      .sem_q     (sem_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        err_sticky <= 1'b0;
      else if (rsvd_hit) err_sticky <= 1'b1;
   end

   assign rd_value = sem_q[rd_idx];

   logic unused_apply;
   assign unused_apply = apply;
endmodule

// File: rtl/sem_cmd_unit_chk.sv
module sem_cmd_unit_chk #(
   parameter int SEM_W = 12,
   parameter int IDX_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [31:0]       cmd_word,
   input logic              cmd_phase,
   input logic              to_dev_idle,
   input logic              from_dev_idle,
   input logic              ext_valid,
   input logic [IDX_W-1:0]  rd_idx,
   input logic [SEM_W-1:0]  rd_value,
   input logic              cmd_done,
   input logic              cmd_blocked,
   input logic              err_sticky
);
   logic live;
   assign live = cmd_valid && cmd_word[31] && (cmd_word[22] == cmd_phase);

   p_disabled_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_word[31]) |-> (cmd_done && !cmd_blocked));

   p_phase_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && (cmd_word[22] != cmd_phase)) |-> cmd_done);

   p_fence_to_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (live && cmd_word[30] && !to_dev_idle) |-> (cmd_blocked && !cmd_done));

   p_fence_from_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (live && cmd_word[29] && !from_dev_idle) |-> (cmd_blocked && !cmd_done));

   p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_sticky |=> err_sticky);

   p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_sticky) |-> $past(cmd_done && cmd_word[31] && cmd_word[26:24] == 3'd7));

   p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |-> (!cmd_done && !cmd_blocked));

   p_hold_value_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!ext_valid && !cmd_valid) && $stable(rd_idx)) |-> $stable(rd_value));
endmodule

bind sem_cmd_unit sem_cmd_unit_chk #(.SEM_W(SEM_W), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
   .cmd_phase(cmd_phase), .to_dev_idle(to_dev_idle), .from_dev_idle(from_dev_idle),
   .ext_valid(ext_valid), .rd_idx(rd_idx), .rd_value(rd_value),
   .cmd_done(cmd_done), .cmd_blocked(cmd_blocked), .err_sticky(err_sticky)
);

// File: tb/sem_cmd_unit_test.sv
module sem_cmd_unit_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [31:0] cmd_word = '0;
   logic        cmd_phase = 1'b0;
   logic        to_dev_idle = 1'b1;
   logic        from_dev_idle = 1'b1;
   logic        ext_valid = 1'b0;
   logic        ext_dec = 1'b0;
   logic [4:0]  ext_idx = '0;
   logic [4:0]  rd_idx = '0;
   logic [11:0] rd_value;
   logic        cmd_done;
   logic        cmd_blocked;
   logic        err_sticky;

   int  model [32];
   bit  model_err;
   int  checks = 0;
   int  errors = 0;
   bit  finished = 0;

   sem_cmd_unit uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
      .cmd_phase(cmd_phase), .to_dev_idle(to_dev_idle), .from_dev_idle(from_dev_idle),
      .ext_valid(ext_valid), .ext_dec(ext_dec), .ext_idx(ext_idx), .rd_idx(rd_idx),
      .rd_value(rd_value), .cmd_done(cmd_done), .cmd_blocked(cmd_blocked),
      .err_sticky(err_sticky)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] mk(bit en, bit ft, bit ff, int op, bit pre, int idx, int val);
      logic [31:0] w = '0;
      w[31] = en; w[30] = ft; w[29] = ff; w[26:24] = op[2:0];
      w[22] = pre; w[20:16] = idx[4:0]; w[11:0] = val[11:0];
      return w;
   endfunction

   function automatic int clampv(int x);
      if (x < 0) return 0;
      if (x > 4095) return 4095;
      return x;
   endfunction

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic step(string tag, logic [31:0] w, bit v, bit ph, bit ti, bit fi,
                       bit ev, bit ed, int ei, int probe);
      int  op, idx, val, cur, base, d;
      bit  active, ready, blk, dn, set;
      cmd_word = w; cmd_valid = v; cmd_phase = ph;
      to_dev_idle = ti; from_dev_idle = fi;
      ext_valid = ev; ext_dec = ed; ext_idx = ei[4:0]; rd_idx = probe[4:0];
      #1;
      op = int'(w[26:24]); idx = int'(w[20:16]); val = int'(w[11:0]);
      cur = model[idx];
      active = w[31] && (w[22] == ph);
      ready = (!w[30] || ti) && (!w[29] || fi);
      if (op == 4) ready = ready && (cur == val);
      if (op == 5) ready = ready && (cur >= val);
      if (op == 6) ready = ready && (cur > 0);
      blk = v && active && !ready;
      dn  = v && !blk;
      chk(tag, "cmd_done", int'(cmd_done), int'(dn));
      chk(tag, "cmd_blocked", int'(cmd_blocked), int'(blk));
      chk(tag, "err_sticky", int'(err_sticky), int'(model_err));
      chk(tag, "rd_value", int'(rd_value), model[probe]);
      @(posedge clk);
      if (dn && active && op == 7) model_err = 1;
      for (int i = 0; i < 32; i++) begin
         set = dn && active && op == 1 && idx == i;
         base = set ? val : model[i];
         d = 0;
         if (dn && active && idx == i) begin
            if (op == 2) d = d + 1;
            if (op == 3 || op == 6) d = d - 1;
         end
         if (ev && ei == i) d = d + (ed ? -1 : 1);
         model[i] = clampv(base + d);
      end
      @(negedge clk);
   endtask

   task automatic cmd(string tag, logic [31:0] w, int probe);
      step(tag, w, 1, 0, 1, 1, 0, 0, 0, probe);
   endtask

   task automatic quiet(string tag, int probe);
      step(tag, '0, 0, 0, 1, 1, 0, 0, 0, probe);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 32; i++) model[i] = 0;
      model_err = 0;
      repeat (3) @(negedge clk);
      // R1: reset state
      for (int i = 0; i < 32; i += 7) begin
         rd_idx = i[4:0]; #1;
         chk("R1", "rd_value", int'(rd_value), 0);
      end
      chk("R1", "err_sticky", int'(err_sticky), 0);
      rst_n = 1'b1;
      @(negedge clk);
      quiet("R1", 31);

      // R4: set
      cmd("R4", mk(1,0,0,1,0,3,100), 3);
      quiet("R4", 3);
      // R5: increment, decrement, saturation
      cmd("R5", mk(1,0,0,2,0,3,0), 3);
      cmd("R5", mk(1,0,0,3,0,3,0), 3);
      cmd("R5", mk(1,0,0,1,0,5,4095), 5);
      cmd("R5", mk(1,0,0,2,0,5,0), 5);
      quiet("R5", 5);
      cmd("R5", mk(1,0,0,3,0,7,0), 7);
      quiet("R5", 7);
      // R2: disabled command
      cmd("R2", mk(0,0,0,1,0,3,7), 3);
      quiet("R2", 3);
      // R3: phase mismatch skipped, match applied
      cmd("R3", mk(1,0,0,1,1,3,9), 3);
      quiet("R3", 3);
      step("R3", mk(1,0,0,1,1,3,9), 1, 1, 1, 1, 0, 0, 0, 3);
      step("R3", mk(1,0,0,2,0,3,0), 1, 1, 1, 1, 0, 0, 0, 3);
      quiet("R3", 3);
      // R12: reserved bits ignored
      cmd("R12", mk(1,0,0,1,0,4,55) | 32'h18A0_F000, 4);
      quiet("R12", 4);
      // R6: equal wait released by the external port
      step("R6", mk(1,0,0,4,0,4,57), 1, 0, 1, 1, 1, 0, 4, 4);
      step("R6", mk(1,0,0,4,0,4,57), 1, 0, 1, 1, 1, 0, 4, 4);
      step("R6", mk(1,0,0,4,0,4,57), 1, 0, 1, 1, 0, 0, 0, 4);
      cmd("R6", mk(1,0,0,5,0,4,50), 4);
      for (int k = 0; k < 3; k++)
         step("R6", mk(1,0,0,5,0,4,60), 1, 0, 1, 1, 1, 0, 4, 4);
      step("R6", mk(1,0,0,5,0,4,60), 1, 0, 1, 1, 0, 0, 0, 4);
      quiet("R6", 4);
      // R7: atomic take
      step("R7", mk(1,0,0,6,0,7,0), 1, 0, 1, 1, 1, 0, 7, 7);
      step("R7", mk(1,0,0,6,0,7,0), 1, 0, 1, 1, 0, 0, 0, 7);
      quiet("R7", 7);
      cmd("R7", mk(1,0,0,6,0,4,0), 4);
      quiet("R7", 4);
      // R11: same-semaphore collisions
      step("R11", mk(1,0,0,1,0,8,10), 1, 0, 1, 1, 1, 0, 8, 8);
      quiet("R11", 8);
      step("R11", mk(1,0,0,2,0,8,0), 1, 0, 1, 1, 1, 1, 8, 8);
      step("R11", mk(1,0,0,3,0,8,0), 1, 0, 1, 1, 1, 1, 8, 8);
      quiet("R11", 8);
      cmd("R11", mk(1,0,0,1,0,9,1), 9);
      step("R11", mk(1,0,0,6,0,9,0), 1, 0, 1, 1, 1, 1, 9, 9);
      quiet("R11", 9);
      // R8: fences
      step("R8", mk(1,1,0,2,0,10,0), 1, 0, 0, 0, 0, 0, 0, 10);
      step("R8", mk(1,1,0,2,0,10,0), 1, 0, 1, 0, 0, 0, 0, 10);
      step("R8", mk(1,0,1,2,0,10,0), 1, 0, 0, 0, 0, 0, 0, 10);
      step("R8", mk(1,0,1,2,0,10,0), 1, 0, 0, 1, 0, 0, 0, 10);
      quiet("R8", 10);
      // R9: no-op and reserved opcode
      cmd("R9", mk(1,0,0,0,0,10,77), 10);
      quiet("R9", 10);
      cmd("R9", mk(1,0,0,7,0,10,77), 10);
      quiet("R9", 10);
      quiet("R9", 10);
      // R10: external port alone, with saturation
      step("R10", '0, 0, 0, 1, 1, 1, 0, 11, 11);
      step("R10", '0, 0, 0, 1, 1, 1, 1, 12, 12);
      step("R10", '0, 0, 0, 1, 1, 1, 0, 5, 5);
      quiet("R10", 11);
      quiet("R10", 5);
      // R13 and mixed traffic on a few semaphores
      for (int k = 0; k < 600; k++) begin
         logic [31:0] w;
         w = mk($urandom_range(0,7) != 0, $urandom_range(0,3) == 0, $urandom_range(0,3) == 0,
                $urandom_range(0,6), $urandom_range(0,1), $urandom_range(0,3), $urandom_range(0,3));
         step("R13", w, $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1),
              $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1),
              $urandom_range(0,3), k % 4);
      end
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule